// File: doc/BRIEF.md
# Edge Event Counter with Match Interrupt and Live Capture

This block is one channel of a timer, working as an event counter. An external pulse line is brought into the system clock domain and edge-detected. Each edge of the chosen polarity (rising or falling) advances a counter. On every edge of the other polarity, the counter is compared with a programmable match value. On equality the block raises a one-cycle interrupt pulse and clears the counter, which then keeps counting without software action.

A small register port lets software program the match value, choose the counting polarity, start or freeze the channel and switch live capture on. While capture is on and the channel runs, the current count is copied into a capture register on every clock. A valid flag tells software when that copy can be trusted: it rises one clock after capture starts, and it drops as soon as the channel stops or capture is switched off.

The control logic is a three-state machine: `ST_IDLE` (frozen), `ST_RUN` (counting) and `ST_MATCH` (the one cycle after a hit, with the interrupt high). Its transitions are:
- start (IDLE to RUN)
- hit (RUN or MATCH to MATCH)
- resume (MATCH to RUN)
- stop (RUN or MATCH to IDLE)

The capture path is a two-state machine: `CAP_OFF` and `CAP_LIVE`, with the transitions enable (OFF to LIVE) and drop (LIVE to OFF).

Top module: `evt_counter_top`

## Requirements
- R1: After reset the channel is frozen (`ST_IDLE`), the interrupt is low, and all four readable registers read zero. The register addresses are: 0 control, 1 match, 2 capture, 3 live count.
- R2: Control bit 1 selects the counting polarity: 0 counts rising edges of `evt_in`, 1 counts falling edges. Edges of the other polarity never advance the count.
- R3: When an edge of the polarity opposite to the counting one is seen and the count equals the match value, `irq` is high for exactly one cycle, and the count reads 0 in that same cycle.
- R4: After a match clears the counter, counting resumes from zero on the following counting edges with no further write.
- R5: Writing control bit 0 = 1 while frozen clears the count and starts the channel. Writing bit 0 = 0 freezes the count, and input edges are then ignored.
- R6: A new match value (address 1) is used from the next comparison on. A match value of zero hits at the first compare edge after the counter has been cleared.
- R7: With control bit 2 = 1 and the channel running, the capture register (address 2) takes the count of the previous cycle on every clock. The valid flag (control read bit 3) reads 1 starting one cycle after capture became active.
- R8: When the channel is frozen or control bit 2 is cleared, the valid flag reads 0 one cycle later, and the capture register keeps its last value.
- R9: An edge on `evt_in` changes the count on the third rising clock edge after the input changes: two synchronizer stages plus the counter register.
- R10: Input phases of at least two clock cycles, high and low, are all counted: N such pulses advance the count by exactly N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | 1 | External event pulse, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 match) |
| wr_data | input | CNT_W | Write data; control uses bits 2:0 |
| rd_addr | input | 2 | Read address (0 control, 1 match, 2 capture, 3 count) |
| rd_data | output | CNT_W | Read data, combinational from `rd_addr` |
| irq | output | 1 | Match interrupt, one-cycle pulse |

## Verification
The assertions rely on two properties of the input:
- Every high and low phase of `evt_in` lasts at least two clocks, so the synchronized edges are never on adjacent cycles.
- The channel leaves the frozen state only through a control write with the run bit set.

The stimulus holds every level of the event line for two to five clocks and performs all starts and stops through the write port. It also uses the shortest legal phase on purpose, to show that no pulse of legal width is lost.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_MATCH = 2'd1,
        A_CAPT  = 2'd2,
        A_COUNT = 2'd3
    } reg_addr_e;

    localparam int unsigned B_RUN   = 0;
    localparam int unsigned B_FALL  = 1;
    localparam int unsigned B_CAP   = 2;
    localparam int unsigned B_VALID = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_MATCH = 2'd2
    } run_state_e;

    typedef enum logic {
        CAP_OFF  = 1'b0,
        CAP_LIVE = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic cap_en;
        logic fall_sel;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign synced = chain_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= synced;
    end

    assign rise = synced & ~prev_q;
    assign fall = ~synced & prev_q;

endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import evt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cap_val,
    input  logic             cap_valid,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] match_val,
    output logic             start_req,
    output logic             stop_req,
    output logic [CNT_W-1:0] rd_data
);
    logic wr_ctrl;
    logic wr_match;

    assign wr_ctrl   = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
    assign wr_match  = wr_en && (reg_addr_e'(wr_addr) == A_MATCH);
    assign start_req = wr_ctrl && wr_data[B_RUN];
    assign stop_req  = wr_ctrl && !wr_data[B_RUN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.run      <= wr_data[B_RUN];
            ctrl.fall_sel <= wr_data[B_FALL];
            ctrl.cap_en   <= wr_data[B_CAP];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           match_val <= '0;
        else if (wr_match) match_val <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            A_CTRL: begin
                rd_data[B_RUN]   = ctrl.run;
                rd_data[B_FALL]  = ctrl.fall_sel;
                rd_data[B_CAP]   = ctrl.cap_en;
                rd_data[B_VALID] = cap_valid;
            end
            A_MATCH: rd_data = match_val;
            A_CAPT:  rd_data = cap_val;
            A_COUNT: rd_data = cnt;
        endcase
    end

endmodule

// File: rtl/evt_ctl_fsm.sv
module evt_ctl_fsm
    import evt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             cnt_edge,
    input  logic             cmp_edge,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq,
    output logic             running
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_e       state_q;
    run_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             hit;

    assign hit = cmp_edge && (cnt_q == match_val);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) state_d = ST_RUN;
            end
            ST_RUN, ST_MATCH: begin
                if (stop_req) state_d = ST_IDLE;
                else if (hit) state_d = ST_MATCH;
                else          state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter datapath
    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) cnt_d = '0;
            end
            ST_RUN, ST_MATCH: begin
                if (stop_req)      cnt_d = cnt_q;
                else if (hit)      cnt_d = '0;
                else if (cnt_edge) cnt_d = cnt_q + ONE;
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // outputs
    always_comb begin
        irq     = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE:  running = 1'b0;
            ST_RUN:   running = 1'b1;
            ST_MATCH: begin
                running = 1'b1;
                irq     = 1'b1;
            end
            default: running = 1'b0;
        endcase
    end

endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import evt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_q,
    output logic             valid
);
    cap_state_e state_q;
    cap_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CAP_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_OFF:  if (active)  state_d = CAP_LIVE;
            CAP_LIVE: if (!active) state_d = CAP_OFF;
            default:  state_d = CAP_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         cap_q <= '0;
        else if (active) cap_q <= cnt;
    end

    always_comb begin
        valid = (state_q == CAP_LIVE);
    end

endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
    import evt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    logic             rise_w;
    logic             fall_w;
    logic             cnt_edge_w;
    logic             cmp_edge_w;
    logic             start_req_w;
    logic             stop_req_w;
    logic             running_w;
    logic             cap_valid_w;
    logic             cap_active_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cap_w;
    logic [CNT_W-1:0] match_w;
    ctrl_t            ctrl_w;

    evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (evt_in),
        .rise (rise_w),
        .fall (fall_w)
    );

    evt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .cnt       (cnt_w),
        .cap_val   (cap_w),
        .cap_valid (cap_valid_w),
        .ctrl      (ctrl_w),
        .match_val (match_w),
        .start_req (start_req_w),
        .stop_req  (stop_req_w),
        .rd_data   (rd_data)
    );

    assign cnt_edge_w   = ctrl_w.fall_sel ? fall_w : rise_w;
    assign cmp_edge_w   = ctrl_w.fall_sel ? rise_w : fall_w;
    assign cap_active_w = running_w && ctrl_w.cap_en;

    evt_ctl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req_w),
        .stop_req  (stop_req_w),
        .cnt_edge  (cnt_edge_w),
        .cmp_edge  (cmp_edge_w),
        .match_val (match_w),
        .cnt_q     (cnt_w),
        .irq       (irq),
        .running   (running_w)
    );

    evt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .active (cap_active_w),
        .cnt    (cnt_w),
        .cap_q  (cap_w),
        .valid  (cap_valid_w)
    );

endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             running,
    input logic             cap_en,
    input logic             cap_valid,
    input logic             rise,
    input logic             fall,
    input logic             start_req
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R3

    AST_IRQ_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == '0)); // R3

    AST_IRQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(running)); // R3

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !start_req) |=> $stable(cnt)); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(running) && (cnt != $past(cnt))) |->
            ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0))); // R4

    AST_VALID_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_valid) |-> $past(cap_en && running)); // R7

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!cap_en || !running) |=> !cap_valid); // R8

    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (rise || fall) |=> !(rise || fall)); // R10

endmodule

bind evt_counter_top evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .cnt       (cnt_w),
    .running   (running_w),
    .cap_en    (ctrl_w.cap_en),
    .cap_valid (cap_valid_w),
    .rise      (rise_w),
    .fall      (fall_w),
    .start_req (start_req_w)
);

// File: tb/evt_counter_top_test.sv
module evt_counter_top_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evt_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit live   = 1'b0;
    bit done   = 1'b0;

    evt_counter_top uut (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    bit           m_s1, m_s2, m_s3;
    bit           m_run, m_fall, m_cap, m_valid, m_irq;
    logic [W-1:0] m_cnt, m_match, m_capv;

    always @(posedge clk) begin
        bit rise, fall, ce, pe, act, hit, wctl, wmat;
        if (rst) begin
            {m_s1, m_s2, m_s3} = 3'b000;
            {m_run, m_fall, m_cap, m_valid, m_irq} = 5'b0;
            m_cnt = '0; m_match = '0; m_capv = '0;
        end else begin
            rise = m_s2 && !m_s3;
            fall = !m_s2 && m_s3;
            ce   = m_fall ? fall : rise;
            pe   = m_fall ? rise : fall;
            act  = m_run && m_cap;
            hit  = pe && (m_cnt == m_match);
            wctl = wr_en && (wr_addr == 2'd0);
            wmat = wr_en && (wr_addr == 2'd1);
            if (act) m_capv = m_cnt;
            m_valid = act;
            m_irq = 1'b0;
            if (wctl && wr_data[0] && !m_run) m_cnt = '0;
            else if (wctl && !wr_data[0]) m_cnt = m_cnt;
            else if (m_run) begin
                if (hit) begin m_cnt = '0; m_irq = 1'b1; end
                else if (ce) m_cnt = m_cnt + 1'b1;
            end
            if (wctl) begin
                m_run = wr_data[0]; m_fall = wr_data[1]; m_cap = wr_data[2];
            end
            if (wmat) m_match = wr_data;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
        end
    end

    function automatic logic [W-1:0] m_read(logic [1:0] a);
        case (a)
            2'd0:    return {{(W-4){1'b0}}, m_valid, m_cap, m_fall, m_run};
            2'd1:    return m_match;
            2'd2:    return m_capv;
            default: return m_cnt;
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !rst) begin
            check("R3", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
            case (rd_addr)
                2'd0:    check("R7", rd_data, m_read(rd_addr));
                2'd1:    check("R6", rd_data, m_read(rd_addr));
                2'd2:    check("R7", rd_data, m_read(rd_addr));
                default: check("R2", rd_data, m_read(rd_addr));
            endcase
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [W-1:0] exp, string req);
        rd_addr = a;
        @(negedge clk);
        check(req, rd_data, exp);
    endtask

    task automatic irq_chk(logic exp, string req);
        @(negedge clk);
        check(req, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, exp});
    endtask

    task automatic level(logic v, int n);
        evt_in = v;
        repeat (n) tick();
    endtask

    task automatic pulse(int h, int l);
        level(1'b1, h);
        level(1'b0, l);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        live = 1'b1;

        // R1 reset state
        irq_chk(1'b0, "R1");
        for (int a = 0; a < 4; a++) rd_chk(2'(a), '0, "R1");

        // R9 latency, rising edges counted
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0001);
        repeat (3) tick();
        rd_addr = 2'd3;
        evt_in = 1'b1;
        tick(); tick();
        rd_chk(2'd3, 16'd0, "R9");
        tick();
        rd_chk(2'd3, 16'd1, "R9");
        tick();
        level(1'b0, 3);
        pulse(3, 3);
        level(1'b1, 3);
        rd_chk(2'd3, 16'd3, "R3");
        level(1'b0, 3);
        irq_chk(1'b1, "R3");
        rd_chk(2'd3, 16'd0, "R3");

        // R4 counting resumes after the clear
        pulse(3, 3);
        rd_chk(2'd3, 16'd1, "R4");
        pulse(3, 3);
        level(1'b1, 3);
        level(1'b0, 3);
        irq_chk(1'b1, "R4");
        rd_chk(2'd3, 16'd0, "R4");

        for (int i = 0; i < 40; i++) begin
            rd_addr = 2'(i);
            pulse(int'($urandom_range(2, 5)), int'($urandom_range(2, 5)));
        end

        // R2 falling edge counting
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0003);
        level(1'b1, 3);
        rd_chk(2'd3, 16'd0, "R2");
        level(1'b0, 3);
        rd_chk(2'd3, 16'd1, "R2");

        // R6 match zero and match rewrite
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0003);
        level(1'b1, 3);
        irq_chk(1'b1, "R6");
        rd_chk(2'd3, 16'd0, "R6");
        wr(2'd1, 16'd2);
        level(1'b0, 3);
        level(1'b1, 3);
        irq_chk(1'b0, "R6");
        level(1'b0, 3);
        level(1'b1, 3);
        irq_chk(1'b1, "R6");

        // R5 freeze and restart
        level(1'b0, 3);
        wr(2'd0, 16'h0002);
        pulse(3, 3); pulse(3, 3); pulse(3, 3);
        rd_chk(2'd3, 16'd1, "R5");
        wr(2'd0, 16'h0003);
        rd_chk(2'd3, 16'd0, "R5");

        // R7 capture valid one cycle after enable
        pulse(3, 3);
        wr(2'd0, 16'h0007);
        rd_chk(2'd0, 16'h0007, "R7");
        tick();
        rd_chk(2'd0, 16'h000F, "R7");
        rd_chk(2'd2, 16'd1, "R7");

        // R8 capture disabled or channel stopped
        wr(2'd0, 16'h0003);
        tick();
        rd_chk(2'd0, 16'h0003, "R8");
        rd_chk(2'd2, 16'd1, "R8");
        pulse(3, 3);
        rd_chk(2'd2, 16'd1, "R8");
        wr(2'd0, 16'h0007);
        tick(); tick();
        wr(2'd0, 16'h0006);
        tick();
        rd_chk(2'd0, 16'h0006, "R8");
        rd_chk(2'd2, 16'd2, "R8");

        // R10 minimum width pulses
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0001);
        for (int i = 0; i < 10; i++) pulse(2, 2);
        repeat (3) tick();
        rd_chk(2'd3, 16'd10, "R10");

        // mixed traffic with live capture
        wr(2'd1, 16'd7);
        wr(2'd0, 16'h0005);
        for (int i = 0; i < 60; i++) begin
            rd_addr = 2'(i);
            if (i == 30) wr(2'd0, 16'h0007);
            pulse(int'($urandom_range(2, 4)), int'($urandom_range(2, 4)));
        end
        repeat (5) tick();
        finish_run();
    end

endmodule